// File: doc/BRIEF.md
# FM Synthesizer Register Write Interface

This block is the host-side register file of a six-channel FM sound generator in which each channel has two operators: a modulator and a carrier. The host drives an indirect write protocol over two ports. A write to the even port loads a register index. A write to the odd port stores a byte at the index loaded last. The index stays in place, so repeated data writes go to the same register.

The register space holds four groups:

- one writable 8-byte user instrument;
- a low frequency byte for each channel;
- a control byte for each channel, holding frequency bit 8, octave, key and sustain;
- an instrument/volume byte for each channel.

Instrument 1 to 15 selects a fixed built-in patch. Instrument 0 selects the user patch.

Each channel's selected patch is decoded at all times into one parameter word per operator, so a change to a user byte reaches every channel that uses it at once. Key transitions written to the control byte produce one-cycle event pulses for the operators. The tone generator that consumes these outputs lies outside this block.

Top module: `fm_reg_if`

## Requirements
- R1: A write with `port_sel_i`=0 loads `wr_data_i[5:0]` as the register index and changes no output. Bits 7:6 are discarded, so index 0xD5 addresses register 0x15.
- R2: A write with `port_sel_i`=1 to index 0x00..0x07 stores user patch byte 0..7. From the next cycle on, every channel whose instrument is 0 shows the new decode.
- R3: Registers 0x10+c hold the low 8 bits of channel c's frequency number. Bit 0 of register 0x20+c is frequency bit 8. `fnum_o[9c+8:9c]` shows the 9-bit number and `block_o[3c+2:3c]` shows bits 3:1 of 0x20+c.
- R4: Register 0x30+c bits 7:4 select the instrument: 0 is the user patch and 1..15 is a built-in patch. Bits 3:0 are the volume. The carrier's level field equals volume×4.
- R5: Operator 2c is channel c's modulator and operator 2c+1 is its carrier. Each has a 37-bit word at `op_param_o[37k+36:37k]` with these fields: ml[3:0], kr[4], eg[5], pm[6], am[7], kl[9:8], tl[15:10], wf[16], fb[19:17], dr[23:20], ar[27:24], rr[31:28], sl[35:32], sus[36].
  - Patch byte 0 gives the modulator am/pm/eg/kr/ml in bits 7,6,5,4,3:0. Byte 1 gives the same fields for the carrier.
  - Byte 2 gives the modulator kl in bits 7:6 and tl in bits 5:0.
  - Byte 3 gives the carrier kl in bits 7:6, the carrier wf in bit 4, the modulator wf in bit 3 and the modulator fb in bits 2:0. The carrier fb is 0.
  - Bytes 4 and 5 give ar in bits 7:4 and dr in bits 3:0, for the modulator and carrier respectively.
  - Bytes 6 and 7 give sl in bits 7:4 and rr in bits 3:0, for the modulator and carrier respectively.
- R6: A write of register 0x20+c with bit 4 set, while the stored key bit is 0, raises `key_on_o[2c]` and `key_on_o[2c+1]` for exactly the next cycle. If the stored key bit is already 1, no pulse is produced.
- R7: A write of register 0x20+c with bit 4 clear, while the stored key bit is 1, raises only `key_off_o[2c+1]` for the next cycle. Modulators never receive key-off pulses.
- R8: Bit 5 of register 0x20+c sets the carrier's sus field. The modulator's sus field is always 0.
- R9: An active-low asynchronous reset clears the index and all registers to 0. All outputs read 0, and the next key-on is accepted.
- R10: Data writes to indices outside the mapped groups change no output. Examples are 0x08..0x0F, 0x16..0x1F, 0x26..0x2F and 0x36..0x3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| port_sel_i | input | 1 | 0 = index port, 1 = data port |
| wr_data_i | input | 8 | Write byte |
| fnum_o | output | 9*NCH | Frequency number per channel |
| block_o | output | 3*NCH | Octave per channel |
| op_param_o | output | 37*2*NCH | Decoded parameter word per operator |
| key_on_o | output | 2*NCH | Key-on pulse per operator |
| key_off_o | output | 2*NCH | Key-off pulse per operator |

## Verification
The bench repeats key-on writes while the key is already held. A design that ignored the stored key bit would retrigger both operators. It also clears the key twice and checks that a key-off reaches the carrier once and never the modulator.

User patch bytes are rewritten while several channels select instrument 0, so a decode that latched the patch only when the instrument was written would show stale fields. Every built-in instrument is stepped through against an independent copy of the patch table. This exposes a wrong byte or a misplaced field.

Index writes with bits 7:6 set and data writes to the gaps in the map are checked to leave all outputs unchanged. A reset in the middle of the run must re-arm key-on.

// File: rtl/fm_reg_pkg.sv
package fm_reg_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 8;
  localparam int NBYTE   = 8;
  localparam int PATCH_W = NBYTE * DATA_W;
  localparam int FNUM_W  = 9;
  localparam int BLK_W   = 3;

  // Register group select from index bits 5:4
  localparam logic [1:0] GRP_FLO = 2'd1;
  localparam logic [1:0] GRP_FHI = 2'd2;
  localparam logic [1:0] GRP_IV  = 2'd3;

  typedef struct packed {
    logic       sus;
    logic [3:0] sl;
    logic [3:0] rr;
    logic [3:0] ar;
    logic [3:0] dr;
    logic [2:0] fb;
    logic       wf;
    logic [5:0] tl;
    logic [1:0] kl;
    logic       am;
    logic       pm;
    logic       eg;
    logic       kr;
    logic [3:0] ml;
  } op_param_t;

  localparam int OPW = $bits(op_param_t);
endpackage

// File: rtl/fm_patch_rom.sv
module fm_patch_rom
  import fm_reg_pkg::*;
(
  input  logic [3:0]         idx_i,
  output logic [PATCH_W-1:0] patch_o
);
  // byte 0 in bits 7:0
  always_comb begin
    unique case (idx_i)
      4'd1:    patch_o = 64'h274281E806052103;
      4'd2:    patch_o = 64'h1223F6D80D144113;
      4'd3:    patch_o = 64'h1220B2FA08081111;
      4'd4:    patch_o = 64'h276164A8070C6131;
      4'd5:    patch_o = 64'h280176E1061E2132;
      4'd6:    patch_o = 64'hF4F4E2A300060102;
      4'd7:    patch_o = 64'h07118182071D6121;
      4'd8:    patch_o = 64'h170172A217222123;
      4'd9:    patch_o = 64'h0172734000251135;
      4'd10:   patch_o = 64'h0251A5A80F0F01B5;
      4'd11:   patch_o = 64'h1222F8F80724C117;
      4'd12:   patch_o = 64'h1618746506112371;
      4'd13:   patch_o = 64'h020395C905D30201;
      4'd14:   patch_o = 64'hF633C094000C6361;
      4'd15:   patch_o = 64'h0656D5C1000D7221;
      default: patch_o = '0;
    endcase
  end
endmodule

// File: rtl/fm_chan_decode.sv
module fm_chan_decode
  import fm_reg_pkg::*;
(
  input  logic [PATCH_W-1:0] cust_i,
  input  logic [DATA_W-1:0]  iv_i,
  input  logic               sus_i,
  output logic [OPW-1:0]     mod_o,
  output logic [OPW-1:0]     car_o
);
  logic [3:0]         inst;
  logic [PATCH_W-1:0] rom_patch;
  logic [PATCH_W-1:0] patch;
  logic [DATA_W-1:0]  pb [NBYTE];
  op_param_t          m, c;
  logic               unused_b3;

  assign inst = iv_i[7:4];

  fm_patch_rom u_rom (.idx_i(inst), .patch_o(rom_patch));

  assign patch = (inst == 4'd0) ? cust_i : rom_patch;

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    assign pb[b] = patch[b*DATA_W +: DATA_W];
  end

  assign unused_b3 = pb[3][5];

  always_comb begin
    m     = '0;
    m.am  = pb[0][7];
    m.pm  = pb[0][6];
    m.eg  = pb[0][5];
    m.kr  = pb[0][4];
    m.ml  = pb[0][3:0];
    m.kl  = pb[2][7:6];
    m.tl  = pb[2][5:0];
    m.wf  = pb[3][3];
    m.fb  = pb[3][2:0];
    m.ar  = pb[4][7:4];
    m.dr  = pb[4][3:0];
    m.sl  = pb[6][7:4];
    m.rr  = pb[6][3:0];
    m.sus = 1'b0;

    c     = '0;
    c.am  = pb[1][7];
    c.pm  = pb[1][6];
    c.eg  = pb[1][5];
    c.kr  = pb[1][4];
    c.ml  = pb[1][3:0];
    c.kl  = pb[3][7:6];
    c.tl  = {iv_i[3:0], 2'b00};
    c.wf  = pb[3][4];
    c.fb  = 3'd0;
    c.ar  = pb[5][7:4];
    c.dr  = pb[5][3:0];
    c.sl  = pb[7][7:4];
    c.rr  = pb[7][3:0];
    c.sus = sus_i;
  end

  assign mod_o = m;
  assign car_o = c;
endmodule

// File: rtl/fm_key_event.sv
module fm_key_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic key_new_i,
  input  logic key_old_i,
  output logic on_o,
  output logic off_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_o  <= 1'b0;
      off_o <= 1'b0;
    end else begin
      on_o  <= hit_i &  key_new_i & ~key_old_i;
      off_o <= hit_i & ~key_new_i &  key_old_i;
    end
  end
endmodule

// File: rtl/fm_reg_if.sv
module fm_reg_if
  import fm_reg_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic                   port_sel_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  output logic [NCH*FNUM_W-1:0]  fnum_o,
  output logic [NCH*BLK_W-1:0]   block_o,
  output logic [2*NCH*OPW-1:0]   op_param_o,
  output logic [2*NCH-1:0]       key_on_o,
  output logic [2*NCH-1:0]       key_off_o
);
  localparam int CH_IDX_W = 4;

  logic [ADDR_W-1:0]  addr_q;
  logic [PATCH_W-1:0] cust_q;
  logic               data_wr;

  assign data_wr = wr_en_i & port_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      addr_q <= '0;
    else if (wr_en_i && !port_sel_i)  addr_q <= wr_data_i[ADDR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cust_q <= '0;
    else if (data_wr && addr_q[5:3] == 3'd0)
      cust_q[{addr_q[2:0], 3'b000} +: DATA_W] <= wr_data_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DATA_W-1:0] flo_q, iv_q;
    logic [5:0]        fhi_q;
    logic              ch_sel, hit_lo, hit_hi, hit_iv;
    logic              kon, koff;

    assign ch_sel = data_wr && (addr_q[CH_IDX_W-1:0] == CH_IDX_W'(c));
    assign hit_lo = ch_sel && (addr_q[5:4] == GRP_FLO);
    assign hit_hi = ch_sel && (addr_q[5:4] == GRP_FHI);
    assign hit_iv = ch_sel && (addr_q[5:4] == GRP_IV);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flo_q <= '0;
        fhi_q <= '0;
        iv_q  <= '0;
      end else begin
        if (hit_lo) flo_q <= wr_data_i;
        if (hit_hi) fhi_q <= wr_data_i[5:0];
        if (hit_iv) iv_q  <= wr_data_i;
      end
    end

    fm_key_event u_key (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hit_i     (hit_hi),
      .key_new_i (wr_data_i[4]),
      .key_old_i (fhi_q[4]),
      .on_o      (kon),
      .off_o     (koff)
    );

    assign key_on_o[2*c]    = kon;
    assign key_on_o[2*c+1]  = kon;
    assign key_off_o[2*c]   = 1'b0;
    assign key_off_o[2*c+1] = koff;

    assign fnum_o[c*FNUM_W +: FNUM_W] = {fhi_q[0], flo_q};
    assign block_o[c*BLK_W +: BLK_W]  = fhi_q[3:1];

    fm_chan_decode u_dec (
      .cust_i (cust_q),
      .iv_i   (iv_q),
      .sus_i  (fhi_q[5]),
      .mod_o  (op_param_o[(2*c)*OPW +: OPW]),
      .car_o  (op_param_o[(2*c+1)*OPW +: OPW])
    );
  end
endmodule

// File: rtl/fm_reg_if_chk.sv
module fm_reg_if_chk
  import fm_reg_pkg::*;
#(
  parameter int NCH = 6
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic                  port_sel_i,
  input logic [NCH*FNUM_W-1:0] fnum_o,
  input logic [NCH*BLK_W-1:0]  block_o,
  input logic [2*NCH*OPW-1:0]  op_param_o,
  input logic [2*NCH-1:0]      key_on_o,
  input logic [2*NCH-1:0]      key_off_o
);
  a_r1_index_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !port_sel_i) |=> ($stable(op_param_o) && $stable(fnum_o) &&
                                  $stable(block_o) && key_on_o == '0 && key_off_o == '0));

  a_r6_on_after_data_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|key_on_o) |-> $past(wr_en_i && port_sel_i));

  a_r7_off_after_data_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|key_off_o) |-> $past(wr_en_i && port_sel_i));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    a_r6_on_both_ops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      key_on_o[2*c] == key_on_o[2*c+1]);
    a_r7_no_mod_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !key_off_o[2*c]);
    a_r8_mod_sus_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !op_param_o[2*c*OPW + OPW - 1]);
    a_r6_on_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      key_on_o[2*c] |=> !key_on_o[2*c]);
    a_r7_off_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      key_off_o[2*c+1] |=> !key_off_o[2*c+1]);
    a_r7_on_off_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(key_on_o[2*c+1] && key_off_o[2*c+1]));
  end
endmodule

bind fm_reg_if fm_reg_if_chk #(.NCH(NCH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .port_sel_i (port_sel_i),
  .fnum_o     (fnum_o),
  .block_o    (block_o),
  .op_param_o (op_param_o),
  .key_on_o   (key_on_o),
  .key_off_o  (key_off_o)
);

// File: tb/fm_reg_if_bench.sv
`timescale 1ns/1ps
module fm_reg_if_bench;
  localparam int NCH = 6;
  localparam int NOP = 2 * NCH;
  localparam int W   = 37;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic port_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [NCH*9-1:0] fnum;
  logic [NCH*3-1:0] blk;
  logic [NOP*W-1:0] opp;
  logic [NOP-1:0]   kon, koff;

  always #2.5 clk = ~clk;

  fm_reg_if #(.NCH(NCH)) u_fm_reg_if (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .port_sel_i(port_sel),
    .wr_data_i(wr_data), .fnum_o(fnum), .block_o(blk), .op_param_o(opp),
    .key_on_o(kon), .key_off_o(koff)
  );

  logic [63:0] rom [15] = '{
    64'h274281E806052103, 64'h1223F6D80D144113, 64'h1220B2FA08081111,
    64'h276164A8070C6131, 64'h280176E1061E2132, 64'hF4F4E2A300060102,
    64'h07118182071D6121, 64'h170172A217222123, 64'h0172734000251135,
    64'h0251A5A80F0F01B5, 64'h1222F8F80724C117, 64'h1618746506112371,
    64'h020395C905D30201, 64'hF633C094000C6361, 64'h0656D5C1000D7221};

  int cust[8];
  int flo[NCH], fhi[NCH], iv[NCH];
  int addr;
  logic [NOP-1:0] exp_on, exp_off;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [36:0] exp_op(int k);
    int c = k / 2;
    int inst = (iv[c] >> 4) & 15;
    int p[8];
    logic [36:0] r;
    for (int b = 0; b < 8; b++)
      p[b] = (inst == 0) ? cust[b] : int'((rom[inst-1] >> (8*b)) & 64'hFF);
    if (k % 2 == 0)
      r = 37'(p[0]) | 37'((p[2] >> 6) & 3) << 8 | 37'(p[2] & 63) << 10 |
          37'((p[3] >> 3) & 1) << 16 | 37'(p[3] & 7) << 17 |
          37'(p[4] & 15) << 20 | 37'((p[4] >> 4) & 15) << 24 |
          37'(p[6] & 15) << 28 | 37'((p[6] >> 4) & 15) << 32;
    else
      r = 37'(p[1]) | 37'((p[3] >> 6) & 3) << 8 | 37'((iv[c] & 15) * 4) << 10 |
          37'((p[3] >> 4) & 1) << 16 |
          37'(p[5] & 15) << 20 | 37'((p[5] >> 4) & 15) << 24 |
          37'(p[7] & 15) << 28 | 37'((p[7] >> 4) & 15) << 32 |
          37'((fhi[c] >> 5) & 1) << 36;
    return r;
  endfunction

  task automatic compare(string tag);
    for (int c = 0; c < NCH; c++) begin
      chk(tag, "fnum", 64'(fnum[c*9 +: 9]), 64'(((fhi[c] & 1) << 8) | flo[c]));
      chk(tag, "block", 64'(blk[c*3 +: 3]), 64'((fhi[c] >> 1) & 7));
    end
    for (int k = 0; k < NOP; k++)
      chk(tag, "op_param", 64'(opp[k*W +: W]), 64'(exp_op(k)));
    chk(tag, "key_on", 64'(kon), 64'(exp_on));
    chk(tag, "key_off", 64'(koff), 64'(exp_off));
  endtask

  task automatic model_clear();
    for (int b = 0; b < 8; b++) cust[b] = 0;
    for (int c = 0; c < NCH; c++) begin flo[c] = 0; fhi[c] = 0; iv[c] = 0; end
    addr = 0; exp_on = '0; exp_off = '0;
  endtask

  task automatic model_write(int a, int d);
    if (a < 8) cust[a] = d;
    else if (a >= 16 && a < 16 + NCH) flo[a-16] = d;
    else if (a >= 32 && a < 32 + NCH) begin
      int c = a - 32;
      int kold = (fhi[c] >> 4) & 1;
      int knew = (d >> 4) & 1;
      if (knew == 1 && kold == 0) begin exp_on[2*c] = 1'b1; exp_on[2*c+1] = 1'b1; end
      if (knew == 0 && kold == 1) exp_off[2*c+1] = 1'b1;
      fhi[c] = d & 63;
    end
    else if (a >= 48 && a < 48 + NCH) iv[a-48] = d;
  endtask

  task automatic wr(bit port, int d);
    wr_en = 1'b1; port_sel = port; wr_data = d[7:0];
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    exp_on = '0; exp_off = '0;
    if (!port) addr = d & 63;
    else model_write(addr, d & 255);
  endtask

  task automatic wreg(int a, int d, string tag);
    wr(1'b0, a);
    compare(tag);
    wr(1'b1, d);
    compare(tag);
  endtask

  task automatic idle(string tag);
    @(posedge clk); @(negedge clk);
    exp_on = '0; exp_off = '0;
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #12;
    model_clear();
    compare("R9");
    @(negedge clk);
    rst_n = 1'b1;
    idle("R9");
  endtask

  initial begin
    int cpat[8] = '{8'hE3, 8'h7C, 8'hB9, 8'h5E, 8'h96, 8'h2F, 8'hC4, 8'h81};
    model_clear();
    do_reset();

    // user patch through instrument 0 on every channel
    for (int b = 0; b < 8; b++) wreg(b, cpat[b], "R2");
    compare("R5");

    // built-in instruments and volume
    wreg(8'h32, 8'h3A, "R4");
    for (int i = 1; i < 16; i++) wreg(8'h30, (i << 4) | (15 - i), "R4");

    // frequency and octave, key stays clear
    wreg(8'h13, 8'hAB, "R3");
    wreg(8'h23, 8'h0B, "R3");

    // key-on, repeat while held, sustain
    wreg(8'h21, 8'h10, "R6");
    idle("R6");
    wr(1'b1, 8'h10); compare("R6");
    wr(1'b1, 8'h35); compare("R8");
    idle("R8");

    // key-off twice
    wr(1'b1, 8'h00); compare("R7");
    idle("R7");
    wr(1'b1, 8'h00); compare("R7");
    for (int c = 0; c < NCH; c++) wreg(8'h20 + c, 8'h10, "R6");
    for (int c = 0; c < NCH; c++) wreg(8'h20 + c, 8'h20, "R7");

    // index masking and quiet index writes
    wr(1'b0, 8'hD5); compare("R1");
    wr(1'b1, 8'h66); compare("R1");
    wr(1'b0, 8'h10); compare("R1");
    wr(1'b0, 8'hF3); compare("R1");

    // unmapped indices
    wreg(8'h08, 8'hFF, "R10");
    wreg(8'h0F, 8'hFF, "R10");
    wreg(8'h16, 8'hFF, "R10");
    wreg(8'h1F, 8'hFF, "R10");
    wreg(8'h26, 8'hFF, "R10");
    wreg(8'h2F, 8'hFF, "R10");
    wreg(8'h36, 8'hFF, "R10");
    wreg(8'h3F, 8'hFF, "R10");

    // user byte change seen by several channels at once
    wreg(8'h34, 8'h07, "R2");
    wreg(8'h31, 8'h0C, "R2");
    wreg(8'h05, 8'h1D, "R2");
    wreg(8'h03, 8'hD2, "R2");

    // reset mid-run re-arms key-on
    wreg(8'h20, 8'h10, "R6");
    do_reset();
    wreg(8'h20, 8'h10, "R9");
    idle("R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule